// File: doc/BRIEF.md
# Receive Stale Data Timeout Unit

This unit watches a receive FIFO for characters that have been sitting without company for too long. Every character that enters the FIFO in the receive direction reloads an 8-bit down-counter from a programmable period register. The counter steps down once per 0.1 ms tick. With the default parameters, a 25 MHz clock is divided by 250 to give a 10 µs pulse, and a divide-by-ten prescaler then gives the tick. The prescaler restarts on every load of the counter, so a one-tick setting expires between 0.09 and 0.1 ms after the last character.

When the counter is at zero, the stale flag is high. While stale, if the FIFO holds at least one whole word (four characters), the unit raises a DMA request. The request stays up until the DMA engine reports completion. If only a partial word remains and no DMA is pending, the unit raises a host interrupt so the host can fetch the leftover character or characters by hand. Both 8-bit registers can be written, and their values are always visible on read ports. A FIFO reset clears the counter, which makes the flag stale.

Top module: `stale_rx_timer`

## Requirements
- R1: After the asynchronous reset, period_o and count_o are 0x00, stale_o is 1, and dma_req_o and irq_o are 0.
- R2: A cycle with reg_wr_i=1 writes reg_wdata_i into the period register when reg_sel_i=0, and into the count register when reg_sel_i=1. The new value appears on period_o or count_o after that clock edge.
- R3: A cycle with char_wr_i=1 and rx_dir_i=1 loads count_o from the period value held before that edge. A char_wr_i pulse with rx_dir_i=0 leaves count_o unchanged.
- R4: The count drops by one per tick, where a tick comes every TICK_DIV pulses of a free-running divide-by-CLK_DIV stage. The tick prescaler restarts on every counter load. With period 1, count_o reaches 0 between (TICK_DIV-1)*CLK_DIV+1 and TICK_DIV*CLK_DIV clock edges after the load edge.
- R5: The count holds at zero and never wraps to 0xFF.
- R6: stale_o is 1 exactly when count_o is 0. It clears on a load of a nonzero value.
- R7: While stale, in the receive direction, with fill_i of 4 or more and no request pending, dma_req_o rises at the next edge. It stays high until the edge on which dma_done_i is 1.
- R8: irq_o is 1 when stale_o=1, rx_dir_i=1, fill_i is 1 to 3 and no DMA request is pending. Otherwise it is 0.
- R9: fifo_rst_i=1 clears the count to 0 and drops any pending DMA request at the next edge. It leaves the period register unchanged.
- R10: With rx_dir_i=0 the count does not decrement.
- R11: When a count-register write and a character load fall in the same cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (25 MHz nominal) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_rst_i | input | 1 | Synchronous FIFO reset |
| rx_dir_i | input | 1 | 1 when the port works in the receive direction |
| char_wr_i | input | 1 | One-cycle pulse per character written into the FIFO |
| fill_i | input | OCC_W | FIFO occupancy in characters |
| dma_done_i | input | 1 | DMA transfer completion pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the period register, 1 selects the count register |
| reg_wdata_i | input | CNT_W | Register write data |
| period_o | output | CNT_W | Period register read port |
| count_o | output | CNT_W | Count register read port |
| stale_o | output | 1 | Stale flag (count at zero) |
| dma_req_o | output | 1 | DMA request for whole words |
| irq_o | output | 1 | Interrupt for a partial-word remainder |

## Verification
The assertions assume that dma_done_i only arrives while a request is pending. They also assume that char_wr_i is a single-cycle pulse and that fill_i changes only between clock edges. The stimulus respects all three: it drives every input just after the falling edge, pulses char_wr_i and dma_done_i for one cycle, and gives completion only after it has seen dma_req_o high. Timing runs use small period values, so that full-tick waits fit in a short run while the prescaler restart is still exercised.

// File: rtl/stale_pkg.sv
package stale_pkg;
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_COUNT  = 1'b1
  } reg_sel_e;

  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_DMA  = 1'b1
  } flush_st_e;
endpackage

// File: rtl/stale_tick_gen.sv
module stale_tick_gen #(
  parameter int CLK_DIV  = 250,
  parameter int TICK_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int US_W  = (CLK_DIV  > 1) ? $clog2(CLK_DIV)  : 1;
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [US_W-1:0]  us_q;
  logic [PRE_W-1:0] pre_q;
  logic             us_pulse;

  assign us_pulse = (us_q == US_W'(CLK_DIV - 1));
  assign tick_o   = us_pulse && (pre_q == PRE_W'(TICK_DIV - 1)) && !clr_i;

  // free-running 10 us stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       us_q <= '0;
    else if (us_pulse) us_q <= '0;
    else               us_q <= us_q + 1'b1;
  end

  // prescaler restarts on every counter load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (clr_i)    pre_q <= '0;
    else if (us_pulse) pre_q <= (pre_q == PRE_W'(TICK_DIV - 1)) ? '0 : pre_q + 1'b1;
  end

  // R4
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_W'(TICK_DIV - 1));

  // R4
  pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);
endmodule

// File: rtl/stale_count_regs.sv
module stale_count_regs
  import stale_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_rst_i,
  input  logic             rx_dir_i,
  input  logic             char_wr_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] count_o,
  output logic             load_o
);
  logic [CNT_W-1:0] period_q, count_q;
  logic             wr_cnt, wr_per, reload;

  assign wr_cnt = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_COUNT);
  assign wr_per = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_PERIOD);
  assign reload = char_wr_i && rx_dir_i;
  assign load_o = fifo_rst_i || wr_cnt || reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     period_q <= '0;
    else if (wr_per) period_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 count_q <= '0;
    else if (fifo_rst_i)                         count_q <= '0;
    else if (wr_cnt)                             count_q <= reg_wdata_i;
    else if (reload)                             count_q <= period_q;
    else if (tick_i && rx_dir_i && count_q != '0) count_q <= count_q - 1'b1;
  end

  assign period_o = period_q;
  assign count_o  = count_q;

  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && !load_o) |=> count_q == '0);

  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> (count_q == $past(count_q)) || (count_q == $past(count_q) - 1'b1));

  // R10
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_dir_i && !load_o) |=> $stable(count_q));

  // R11
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt && !fifo_rst_i) |=> count_q == $past(reg_wdata_i));
endmodule

// File: rtl/stale_flush_ctl.sv
module stale_flush_ctl
  import stale_pkg::*;
#(
  parameter int OCC_W      = 6,
  parameter int WORD_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_rst_i,
  input  logic             stale_i,
  input  logic             rx_dir_i,
  input  logic [OCC_W-1:0] fill_i,
  input  logic             dma_done_i,
  output logic             dma_req_o,
  output logic             irq_o
);
  flush_st_e st_q, st_d;
  logic      whole, partial;

  assign whole   = fill_i >= OCC_W'(WORD_CHARS);
  assign partial = (fill_i != '0) && !whole;

  always_comb begin
    st_d = st_q;
    if (fifo_rst_i)                                   st_d = FL_IDLE;
    else if (st_q == FL_DMA && dma_done_i)            st_d = FL_IDLE;
    else if (st_q == FL_IDLE && stale_i && rx_dir_i && whole) st_d = FL_DMA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FL_IDLE;
    else         st_q <= st_d;
  end

  assign dma_req_o = (st_q == FL_DMA);
  assign irq_o     = stale_i && rx_dir_i && partial && (st_q == FL_IDLE);

  // R7
  dma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !dma_done_i && !fifo_rst_i) |=> dma_req_o);

  // R9
  rst_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> !dma_req_o);

  // R8
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && dma_req_o));
endmodule

// File: rtl/stale_rx_timer.sv
module stale_rx_timer #(
  parameter int CLK_DIV    = 250,
  parameter int TICK_DIV   = 10,
  parameter int CNT_W      = 8,
  parameter int OCC_W      = 6,
  parameter int WORD_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_rst_i,
  input  logic             rx_dir_i,
  input  logic             char_wr_i,
  input  logic [OCC_W-1:0] fill_i,
  input  logic             dma_done_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] count_o,
  output logic             stale_o,
  output logic             dma_req_o,
  output logic             irq_o
);
  logic load, tick;

  stale_tick_gen #(.CLK_DIV(CLK_DIV), .TICK_DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(load), .tick_o(tick)
  );

  stale_count_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .fifo_rst_i, .rx_dir_i, .char_wr_i,
    .reg_wr_i, .reg_sel_i, .reg_wdata_i, .tick_i(tick),
    .period_o, .count_o, .load_o(load)
  );

  assign stale_o = (count_o == '0);

  stale_flush_ctl #(.OCC_W(OCC_W), .WORD_CHARS(WORD_CHARS)) u_flush (
    .clk_i, .rst_ni, .fifo_rst_i, .stale_i(stale_o), .rx_dir_i,
    .fill_i, .dma_done_i, .dma_req_o, .irq_o
  );

  // R6
  unstale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i && reg_wdata_i != '0 && !fifo_rst_i) |=> !stale_o);

  // R9
  fifo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> (stale_o && $stable(period_o)));
endmodule

// File: tb/sim_stale_rx_timer.sv
module sim_stale_rx_timer;
  localparam int CLK_DIV = 250, TICK_DIV = 10;

  logic       clk = 0, rst_ni = 0;
  logic       fifo_rst = 0, rx_dir = 1, char_wr = 0, dma_done = 0;
  logic [5:0] fill = 0;
  logic       reg_wr = 0, reg_sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] period_o, count_o;
  logic       stale_o, dma_req_o, irq_o;

  int tests = 0, fails = 0;
  bit done = 0;

  // model state
  int m_us = 0, m_pre = 0, m_cnt = 0, m_per = 0;
  bit m_busy = 0;

  always #2 clk = ~clk;

  stale_rx_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_rst_i(fifo_rst), .rx_dir_i(rx_dir),
    .char_wr_i(char_wr), .fill_i(fill), .dma_done_i(dma_done),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(wdata),
    .period_o(period_o), .count_o(count_o), .stale_o(stale_o),
    .dma_req_o(dma_req_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated each edge, compared 1 ns later
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_us = 0; m_pre = 0; m_cnt = 0; m_per = 0; m_busy = 0;
    end else begin
      bit ld, pulse, tk, nbusy;
      int ncnt;
      ld    = fifo_rst || (reg_wr && reg_sel) || (char_wr && rx_dir);
      pulse = (m_us == CLK_DIV - 1);
      tk    = pulse && (m_pre == TICK_DIV - 1) && !ld;
      if (fifo_rst)                        ncnt = 0;
      else if (reg_wr && reg_sel)          ncnt = wdata;
      else if (char_wr && rx_dir)          ncnt = m_per;
      else if (tk && rx_dir && m_cnt > 0)  ncnt = m_cnt - 1;
      else                                 ncnt = m_cnt;
      if (fifo_rst)                        nbusy = 0;
      else if (m_busy && dma_done)         nbusy = 0;
      else if (!m_busy && m_cnt == 0 && rx_dir && fill >= 4) nbusy = 1;
      else                                 nbusy = m_busy;
      if (reg_wr && !reg_sel) m_per = wdata;
      if (ld) m_pre = 0;
      else if (pulse) m_pre = (m_pre == TICK_DIV - 1) ? 0 : m_pre + 1;
      m_us = pulse ? 0 : m_us + 1;
      m_cnt = ncnt; m_busy = nbusy;
      #1;
      if (!done) begin
        chk("R2 period", period_o, m_per);
        chk("R4 count", count_o, m_cnt);
        chk("R6 stale", stale_o, m_cnt == 0);
        chk("R7 dma_req", dma_req_o, m_busy);
        chk("R8 irq", irq_o, (m_cnt == 0) && rx_dir && fill >= 1 && fill < 4 && !m_busy);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input int v);
    reg_wr = 1; reg_sel = sel; wdata = 8'(v);
    cyc(1); reg_wr = 0;
  endtask

  task automatic pulse_char();
    char_wr = 1; cyc(1); char_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(1);
    // R1 reset state
    chk("R1 period", period_o, 0);
    chk("R1 count", count_o, 0);
    chk("R1 stale", stale_o, 1);
    chk("R1 dma", dma_req_o, 0);
    chk("R1 irq", irq_o, 0);
    cyc(2); rst_ni = 1; cyc(2);

    // R2 register writes
    wr(0, 2);
    chk("R2 period write", period_o, 2);
    wr(1, 5);
    chk("R2 count write", count_o, 5);
    chk("R6 stale low", stale_o, 0);

    // R9 fifo reset
    fifo_rst = 1; cyc(1); fifo_rst = 0;
    chk("R9 count cleared", count_o, 0);
    chk("R9 stale set", stale_o, 1);
    chk("R9 period kept", period_o, 2);

    // R3 reload
    pulse_char();
    chk("R3 reload", count_o, 2);
    chk("R6 stale clears", stale_o, 0);

    // R4 timing with period 1
    wr(0, 1);
    pulse_char();
    chk("R3 reload p1", count_o, 1);
    begin
      int n = 0;
      while (count_o != 0 && n < 5000) begin
        @(posedge clk); #1; n++;
      end
      chk("R4 delay lower", int'(n >= (TICK_DIV - 1) * CLK_DIV + 1), 1);
      chk("R4 delay upper", int'(n <= TICK_DIV * CLK_DIV), 1);
    end

    // R5 hold at zero
    cyc(3000);
    chk("R5 no wrap", count_o, 0);

    // R3 ignored when not receiving
    wr(0, 3);
    rx_dir = 0; pulse_char();
    chk("R3 tx char ignored", count_o, 0);

    // R10 no decrement in transmit
    rx_dir = 1; pulse_char(); rx_dir = 0;
    cyc(6000);
    chk("R10 held", count_o, 3);
    rx_dir = 1;

    // R11 write wins over reload
    reg_wr = 1; reg_sel = 1; wdata = 8'd7; char_wr = 1;
    cyc(1); reg_wr = 0; char_wr = 0;
    chk("R11 write wins", count_o, 7);

    // R7 DMA flush
    wr(1, 0);
    fill = 6; cyc(1);
    chk("R7 dma raised", dma_req_o, 1);
    cyc(10);
    chk("R7 dma held", dma_req_o, 1);
    chk("R8 no irq while dma", irq_o, 0);
    fill = 1; dma_done = 1; cyc(1); dma_done = 0;
    chk("R7 dma dropped", dma_req_o, 0);
    chk("R8 irq single", irq_o, 1);
    fill = 3; cyc(1);
    chk("R8 irq partial", irq_o, 1);
    fill = 0; cyc(1);
    chk("R8 irq empty", irq_o, 0);

    // R9 fifo reset drops request
    fill = 8; cyc(2);
    chk("R7 dma again", dma_req_o, 1);
    fifo_rst = 1; cyc(1); fifo_rst = 0; fill = 0;
    chk("R9 dma dropped", dma_req_o, 0);
    cyc(3);
    finish_run();
  end
endmodule